// File: doc/BRIEF.md
# Coalescing Masked Store Buffer

This block sits between a processor's store port and its data cache and holds stores to lines that the cache does not yet own. A store carries a byte address, one word of data and a byte enable per data lane. Each buffer entry records one line address, the values stored into that line and a bit mask the width of the whole line. A mask bit is 1 where that bit position has been written and 0 elsewhere. The data bits under a 0 mask bit are don't-care. The storing side never has the rest of the line, so an entry holds only what was written.

A store that misses every entry takes a free entry. One cycle later the block issues a request for the line with ownership, which reads the line and invalidates other copies, because the unwritten part of the line is still needed. Later stores to the same line coalesce into the same entry, and the newer bytes replace the older ones. When the line arrives on the fill input, every masked bit takes the buffered value and every unmasked bit keeps the arriving value. The merged line goes to the cache write port one cycle later and the entry is freed. A fill that matches no entry passes through unchanged. A store in the same cycle as the fill for its line is folded into that merged line.

Top module: `coalescing_store_buffer`

## Requirements
- R1: After reset no entry is in use: `st_ready` is 1, and `own_req_valid` and `cwr_valid` are 0.
- R2: An accepted store whose line (`st_addr[31:4]`) matches no entry and no same-cycle fill takes an entry. In the next cycle `own_req_valid` is 1 for exactly one cycle, with `own_req_line` equal to that line.
- R3: An accepted store to a line that already has an entry raises no request. It coalesces into that entry: the enabled bytes overwrite older buffered bytes, and the mask becomes the OR of the old mask and the new byte mask.
- R4: A fill whose `fill_line` matches an entry produces, in the next cycle, `cwr_valid`=1 and `cwr_line`=`fill_line`. Each line byte in `cwr_data` is the last buffered value where it was written, and the fill byte elsewhere. The entry is then free, so a later store to that line raises a new request.
- R5: A fill that matches no entry (and no same-cycle store) is written out unchanged in the next cycle, with `cwr_data`=`fill_data`.
- R6: A store whose line equals `fill_line` in a cycle with `fill_valid` is accepted, takes no entry and raises no request. Its enabled bytes are part of that fill's `cwr_data`, over any older buffered bytes.
- R7: With all entries in use, a store that matches no entry and no same-cycle fill sees `st_ready`=0, and no entry is taken. A store that hits an entry is still accepted.
- R8: Line byte k is `cwr_data[8k+7:8k]`. A store places `st_data[8j+7:8j]` at line byte 4*`st_addr[3:2]`+j when `st_be[j]`=1. Data in lanes with `st_be[j]`=0 never affects `cwr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data, one byte per lane |
| st_be | input | 4 | Byte enable per lane |
| own_req_valid | output | 1 | Request for a line with ownership (read and invalidate) |
| own_req_line | output | 28 | Line address of the request |
| fill_valid | input | 1 | Returned line present |
| fill_line | input | 28 | Line address of the returned line |
| fill_data | input | 128 | Returned line contents |
| cwr_valid | output | 1 | Cache line write |
| cwr_line | output | 28 | Line address of the write |
| cwr_data | output | 128 | Merged line contents |

## Verification
Directed cases cover a single low byte in a 16-byte line, which tells a byte-accurate merge apart from a whole-word or whole-line overwrite. Overlapping stores to one word, with partial enables and junk data in the disabled lanes, tell newest-wins coalescing apart from keeping the oldest value or ignoring the mask. Other cases cover a fill with no entry, a store and a fill to the same line in one cycle, and filling every entry and then sending one more miss. These show that pass-through, same-cycle folding and back-pressure are separate paths. Random traffic over six lines and four entries then mixes hits, misses, stalls and fills, with and without entries, against a line-indexed reference model.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int SB_ADDR_W     = 32;
  localparam int SB_LINE_BYTES = 16;
  localparam int SB_WORD_BYTES = 4;
  localparam int SB_ENTRIES    = 4;
endpackage

// File: rtl/sb_alloc.sv
module sb_alloc #(
  parameter int N = 4
) (
  input  logic [N-1:0] busy,
  output logic [N-1:0] grant,
  output logic         any_free
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) grant = N'(1) << i;
    end
  end

  assign any_free = ~&busy;
endmodule

// File: rtl/sb_merge.sv
module sb_merge #(
  parameter int LINE_W = 128
) (
  input  logic [LINE_W-1:0] line_in,
  input  logic [LINE_W-1:0] buf_data,
  input  logic [LINE_W-1:0] buf_mask,
  output logic [LINE_W-1:0] line_out
);
  assign line_out = (line_in & ~buf_mask) | (buf_data & buf_mask);
endmodule

// File: rtl/sb_entry.sv
module sb_entry #(
  parameter int TAG_W  = 28,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              upd,
  input  logic              clr,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [LINE_W-1:0] wdata,
  input  logic [LINE_W-1:0] wmask,
  output logic              valid,
  output logic [TAG_W-1:0]  tag,
  output logic [LINE_W-1:0] data,
  output logic [LINE_W-1:0] mask
);
  logic              valid_d;
  logic [TAG_W-1:0]  tag_d;
  logic [LINE_W-1:0] data_d, mask_d;
  logic              en;

  assign en = alloc | upd | clr;

  always_comb begin
    valid_d = valid;
    tag_d   = tag;
    data_d  = data;
    mask_d  = mask;
    if (clr) begin
      valid_d = 1'b0;
      mask_d  = '0;
    end else if (alloc) begin
      valid_d = 1'b1;
      tag_d   = tag_in;
      data_d  = wdata & wmask;
      mask_d  = wmask;
    end else if (upd) begin
      data_d  = (data & ~wmask) | (wdata & wmask);
      mask_d  = mask | wmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      mask  <= '0;
    end else if (en) begin
      valid <= valid_d;
      mask  <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      tag  <= tag_d;
      data <= data_d;
    end
  end

  // R3
  mask_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && !$past(clr)) |-> ((mask & $past(mask)) == $past(mask)));

  // R3
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && !$past(clr)) |-> (tag == $past(tag)));
endmodule

// File: rtl/coalescing_store_buffer.sv
module coalescing_store_buffer
  import sb_pkg::*;
#(
  parameter int ADDR_W     = SB_ADDR_W,
  parameter int LINE_BYTES = SB_LINE_BYTES,
  parameter int WORD_BYTES = SB_WORD_BYTES,
  parameter int ENTRIES    = SB_ENTRIES
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    st_valid,
  output logic                                    st_ready,
  input  logic [ADDR_W-1:0]                       st_addr,
  input  logic [WORD_BYTES*8-1:0]                 st_data,
  input  logic [WORD_BYTES-1:0]                   st_be,
  output logic                                    own_req_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    own_req_line,
  input  logic                                    fill_valid,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    fill_line,
  input  logic [LINE_BYTES*8-1:0]                 fill_data,
  output logic                                    cwr_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]    cwr_line,
  output logic [LINE_BYTES*8-1:0]                 cwr_data
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LANE_W = $clog2(WORD_BYTES);
  localparam int IDX_W  = (OFF_W > LANE_W) ? OFF_W - LANE_W : 1;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int WORD_W = WORD_BYTES * 8;
  localparam int LINE_W = LINE_BYTES * 8;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  // store decode
  logic [TAG_W-1:0]  st_line;
  logic [IDX_W-1:0]  st_widx;
  logic [WORD_W-1:0] st_wmask;
  logic [LINE_W-1:0] st_ldata, st_lmask;

  assign st_line = st_addr[ADDR_W-1:OFF_W];
  assign st_widx = IDX_W'(st_addr[OFF_W-1:0] >> LANE_W);

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    assign st_wmask[b*8 +: 8] = {8{st_be[b]}};
  end

  assign st_ldata = LINE_W'(st_data)  << (int'(st_widx) * WORD_W);
  assign st_lmask = LINE_W'(st_wmask) << (int'(st_widx) * WORD_W);

  // entries
  logic [ENTRIES-1:0] ent_valid, hit_vec, fhit_vec, grant;
  logic [ENTRIES-1:0] alloc_v, upd_v;
  logic [TAG_W-1:0]   ent_tag  [ENTRIES];
  logic [LINE_W-1:0]  ent_data [ENTRIES];
  logic [LINE_W-1:0]  ent_mask [ENTRIES];
  logic               any_free, st_hit, st_fold, st_acc, do_alloc;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign hit_vec[i]  = ent_valid[i] && (ent_tag[i] == st_line);
    assign fhit_vec[i] = fill_valid && ent_valid[i] && (ent_tag[i] == fill_line);
    assign alloc_v[i]  = do_alloc && grant[i];
    assign upd_v[i]    = st_acc && hit_vec[i] && !st_fold;

    sb_entry #(.TAG_W(TAG_W), .LINE_W(LINE_W)) u_entry (
      .clk    (clk),
      .rst_n  (rst_s),
      .alloc  (alloc_v[i]),
      .upd    (upd_v[i]),
      .clr    (fhit_vec[i]),
      .tag_in (st_line),
      .wdata  (st_ldata),
      .wmask  (st_lmask),
      .valid  (ent_valid[i]),
      .tag    (ent_tag[i]),
      .data   (ent_data[i]),
      .mask   (ent_mask[i])
    );
  end

  sb_alloc #(.N(ENTRIES)) u_alloc (
    .busy     (ent_valid),
    .grant    (grant),
    .any_free (any_free)
  );

  assign st_hit   = |hit_vec;
  assign st_fold  = fill_valid && (st_line == fill_line);
  assign st_ready = st_hit || st_fold || any_free;
  assign st_acc   = st_valid && st_ready;
  assign do_alloc = st_acc && !st_hit && !st_fold;

  // fill path: select matching entry, fold same-cycle store
  logic [LINE_W-1:0] sel_data, sel_mask, mrg_data, mrg_mask, merged;

  always_comb begin
    sel_data = '0;
    sel_mask = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fhit_vec[i]) begin
        sel_data = sel_data | ent_data[i];
        sel_mask = sel_mask | ent_mask[i];
      end
    end
    if (st_valid && st_fold) begin
      mrg_data = (sel_data & ~st_lmask) | (st_ldata & st_lmask);
      mrg_mask = sel_mask | st_lmask;
    end else begin
      mrg_data = sel_data;
      mrg_mask = sel_mask;
    end
  end

  sb_merge #(.LINE_W(LINE_W)) u_merge (
    .line_in  (fill_data),
    .buf_data (mrg_data),
    .buf_mask (mrg_mask),
    .line_out (merged)
  );

  // output registers
  logic              req_v_d, cwr_v_d;
  logic [TAG_W-1:0]  req_line_d, cwr_line_d;
  logic [LINE_W-1:0] cwr_data_d;

  always_comb begin
    req_v_d    = do_alloc;
    req_line_d = st_line;
    cwr_v_d    = fill_valid;
    cwr_line_d = fill_line;
    cwr_data_d = merged;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      own_req_valid <= 1'b0;
      cwr_valid     <= 1'b0;
    end else begin
      own_req_valid <= req_v_d;
      cwr_valid     <= cwr_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_v_d) own_req_line <= req_line_d;
    if (cwr_v_d) begin
      cwr_line <= cwr_line_d;
      cwr_data <= cwr_data_d;
    end
  end

  // R3
  one_hit_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(hit_vec));

  // R7
  stall_full_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !st_ready |-> (&ent_valid));

  // R2
  req_line_chk: assert property (@(posedge clk) disable iff (!rst_s)
    own_req_valid |-> (own_req_line == $past(st_line)));

  // R5
  fill_keep_chk: assert property (@(posedge clk) disable iff (!rst_s)
    cwr_valid |-> (((cwr_data ^ $past(fill_data)) & ~$past(mrg_mask)) == '0));

  // R4
  fill_free_chk: assert property (@(posedge clk) disable iff (!rst_s)
    cwr_valid |-> (cwr_line == $past(fill_line)));
endmodule

// File: tb/tb_coalescing_store_buffer.sv
module tb_coalescing_store_buffer;
  localparam int NENT = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid;
  logic         st_ready;
  logic [31:0]  st_addr;
  logic [31:0]  st_data;
  logic [3:0]   st_be;
  logic         own_req_valid;
  logic [27:0]  own_req_line;
  logic         fill_valid;
  logic [27:0]  fill_line;
  logic [127:0] fill_data;
  logic         cwr_valid;
  logic [27:0]  cwr_line;
  logic [127:0] cwr_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [127:0] em_data [int];
  logic [127:0] em_mask [int];

  always #10 clk = ~clk;

  coalescing_store_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be),
    .own_req_valid(own_req_valid), .own_req_line(own_req_line),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
    .cwr_valid(cwr_valid), .cwr_line(cwr_line), .cwr_data(cwr_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] lane_mask(input logic [31:0] a, input logic [3:0] be);
    logic [127:0] m = '0;
    for (int j = 0; j < 4; j++)
      if (be[j]) m[(a[3:2]*4 + j)*8 +: 8] = 8'hff;
    return m;
  endfunction

  function automatic logic [127:0] lane_data(input logic [31:0] a, input logic [31:0] d);
    logic [127:0] v = '0;
    for (int j = 0; j < 4; j++) v[(a[3:2]*4 + j)*8 +: 8] = d[j*8 +: 8];
    return v;
  endfunction

  task automatic step(input string req, input bit sv, input logic [31:0] sa,
                      input logic [31:0] sd, input logic [3:0] sb,
                      input bit fv, input logic [27:0] fl, input logic [127:0] fd);
    int sl;
    bit hit, fold, rdy, acc, alloc;
    logic [127:0] m, d, bd, bm, ew;
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
    fill_valid = fv; fill_line = fl; fill_data = fd;
    #1;
    sl   = int'(sa[31:4]);
    hit  = em_data.exists(sl);
    fold = fv && (sa[31:4] == fl);
    rdy  = hit || fold || (em_data.num() < NENT);
    chk(req, "st_ready", 128'(st_ready), 128'(rdy));
    acc   = sv && rdy;
    alloc = 1'b0;
    m = lane_mask(sa, sb);
    d = lane_data(sa, sd);
    ew = '0;
    if (fv) begin
      bd = em_data.exists(int'(fl)) ? em_data[int'(fl)] : '0;
      bm = em_mask.exists(int'(fl)) ? em_mask[int'(fl)] : '0;
      if (acc && fold) begin
        bd = (bd & ~m) | (d & m);
        bm = bm | m;
      end
      ew = (fd & ~bm) | (bd & bm);
      if (em_data.exists(int'(fl))) begin
        em_data.delete(int'(fl));
        em_mask.delete(int'(fl));
      end
    end
    if (acc && !fold) begin
      if (hit) begin
        em_data[sl] = (em_data[sl] & ~m) | (d & m);
        em_mask[sl] = em_mask[sl] | m;
      end else begin
        alloc = 1'b1;
        em_data[sl] = d & m;
        em_mask[sl] = m;
      end
    end
    @(posedge clk);
    #1;
    chk(req, "own_req_valid", 128'(own_req_valid), 128'(alloc));
    if (alloc) chk(req, "own_req_line", 128'(own_req_line), 128'(sa[31:4]));
    chk(req, "cwr_valid", 128'(cwr_valid), 128'(fv));
    if (fv) begin
      chk(req, "cwr_line", 128'(cwr_line), 128'(fl));
      chk(req, "cwr_data", cwr_data, ew);
    end
  endtask

  task automatic idle(input string req);
    step(req, 1'b0, 32'h0, 32'h0, 4'h0, 1'b0, 28'h0, 128'h0);
  endtask

  function automatic logic [127:0] rnd_line();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] pat;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    st_valid = 0; st_addr = 0; st_data = 0; st_be = 0;
    fill_valid = 0; fill_line = 0; fill_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "st_ready", 128'(st_ready), 128'(1));
    chk("R1", "own_req_valid", 128'(own_req_valid), 128'(0));
    chk("R1", "cwr_valid", 128'(cwr_valid), 128'(0));

    // R2 / R4 / R8: single low byte 0x5a in a 16-byte line, junk in disabled lanes
    step("R2", 1'b1, {28'h100, 4'h0}, 32'hAABBCC5a, 4'b0001, 1'b0, 28'h0, 128'h0);
    idle("R2");
    pat = rnd_line();
    step("R4", 1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 28'h100, pat);
    chk("R8", "byte0", 128'(cwr_data[7:0]), 128'(8'h5a));
    chk("R4", "bytes1to15", 128'(cwr_data[127:8]), 128'(pat[127:8]));

    // R3 coalescing with newest-wins
    step("R3", 1'b1, {28'h110, 4'h4}, 32'h11223344, 4'b1111, 1'b0, 28'h0, 128'h0);
    step("R3", 1'b1, {28'h110, 4'h4}, 32'hDEADBEEF, 4'b0110, 1'b0, 28'h0, 128'h0);
    step("R3", 1'b1, {28'h110, 4'hC}, 32'h77000000, 4'b1000, 1'b0, 28'h0, 128'h0);
    step("R3", 1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 28'h110, rnd_line());
    chk("R3", "word1", 128'(cwr_data[63:32]), 128'(32'h11ADBE44));
    // R4 freed entry: new request for same line
    step("R4", 1'b1, {28'h110, 4'h0}, 32'h1, 4'b0001, 1'b0, 28'h0, 128'h0);
    step("R4", 1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 28'h110, rnd_line());

    // R5 fill with no entry passes unchanged
    pat = rnd_line();
    step("R5", 1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 28'h200, pat);
    chk("R5", "passthru", cwr_data, pat);

    // R6 same-cycle store and fill, with and without an entry
    step("R6", 1'b1, {28'h300, 4'h0}, 32'hCAFEF00D, 4'b1111, 1'b0, 28'h0, 128'h0);
    step("R6", 1'b1, {28'h300, 4'h8}, 32'h55AA55AA, 4'b0011, 1'b1, 28'h300, rnd_line());
    step("R6", 1'b1, {28'h400, 4'h4}, 32'h0BADCAFE, 4'b1100, 1'b1, 28'h400, rnd_line());

    // R7 full: four lines fill the buffer, a fifth miss stalls, a hit passes
    for (int k = 0; k < 4; k++)
      step("R7", 1'b1, {28'h500 + 28'(k), 4'h0}, $urandom, 4'b1111, 1'b0, 28'h0, 128'h0);
    step("R7", 1'b1, {28'h5FF, 4'h0}, 32'h12345678, 4'b1111, 1'b0, 28'h0, 128'h0);
    step("R7", 1'b1, {28'h502, 4'h8}, 32'h9, 4'b0001, 1'b0, 28'h0, 128'h0);
    for (int k = 0; k < 4; k++)
      step("R7", 1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 28'h500 + 28'(k), rnd_line());

    // random mix over six lines
    for (int n = 0; n < 3000; n++) begin
      bit sv, fv;
      logic [31:0] a;
      sv = ($urandom % 10) < 7;
      fv = ($urandom % 10) < 3;
      a  = {28'h700 + 28'($urandom % 6), 2'($urandom), 2'b00};
      step("R8", sv, a, $urandom, 4'($urandom), fv, 28'h700 + 28'($urandom % 6), rnd_line());
    end
    for (int k = 0; k < 6; k++)
      step("R4", 1'b0, 32'h0, 32'h0, 4'h0, 1'b1, 28'h700 + 28'(k), rnd_line());
    idle("R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule